// File: doc/BRIEF.md
# Switchable Round-Robin / Rotated-Priority DMA Bus Arbiter

This block decides which of four DMA requesters may drive one shared local bus. Each requester raises a request line, and the arbiter answers with a one-hot grant. The grant stays in place for as long as the owning requester keeps its request high. A new decision is taken only when the bus is free or its owner has just let go. Ownership is therefore never taken away from an active requester.

A 3-bit control field in an 8-bit register selects the policy. It is reached over a byte-wide port with a chip-select and a write-enable, and it reads back with zero wait states. With the mode bit clear, the arbiter rotates: the most recent winner drops to last place and the search starts at the slot after it. With the mode bit set, the arbiter ranks the slots in a fixed order. That order is one of four rotations of the slot list, and a 2-bit code picks which one.

A strap input states how the four request slots are wired to sockets. They can be four single-channel sockets a, b, c and d, or two dual-channel sockets a and c. A registered owner code reports the socket and channel that currently hold the bus.

Top module: `dma_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant, the owner code and the control field. After reset the arbiter is in rotating mode with priority code 00.
- R2: The control register is 8 bits. Bit 2 is the mode bit (1 = fixed, 0 = rotating) and bits 1:0 are the priority code; these three bits are read/write. Bits 7:3 read as 0 and ignore writes. The read bus returns the register in the same cycle while chip-select is high, and returns 0 otherwise.
- R3: A write happens only when chip-select and write-enable are both high at a clock edge. Any other combination leaves the register unchanged.
- R4: The grant is one-hot or zero, and it goes only to a slot whose request was high at the deciding edge. If no request is high and nobody owns the bus, the grant is zero.
- R5: While the owner's request stays high, its grant is held unchanged whatever the other requests do.
- R6: When the owner's request is low at an edge, the grant moves at that same edge to the next winner, or to zero if no one is requesting.
- R7: In rotating mode the search begins at the slot after the most recently granted one, wrapping from 3 to 0. Straight after reset the search begins at slot 0.
- R8: In fixed mode the search begins at the slot named by the priority code and goes up with wrap-around. Code 0 gives 0>1>2>3, code 1 gives 1>2>3>0, code 2 gives 2>3>0>1 and code 3 gives 3>0>1>2.
- R9: A register write is used from the next decision onward. It never changes the current owner.
- R10: With the dual-socket strap low, slot n is reported as socket n (0=a, 1=b, 2=c, 3=d) on channel 0.
- R11: With the dual-socket strap high, slots 0..3 are reported as socket a ch0, socket a ch1, socket c ch0 and socket c ch1. The socket codes are 0 for a and 2 for c.
- R12: In rotating mode, when all four requesters keep asking and each releases after a short tenure, grants go round 0,1,2,3 and every slot receives the same number of grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual_socket | input | 1 | 1 = two dual-channel sockets, 0 = four single-channel sockets |
| req | input | N_REQ | Request line per slot |
| grant | output | N_REQ | One-hot registered grant |
| owner_valid | output | 1 | The bus has an owner |
| owner_socket | output | IDX_W | Socket code of the owner |
| owner_chan | output | 1 | Channel of the owner within its socket |
| reg_cs | input | 1 | Register chip-select |
| reg_we | input | 1 | Register write-enable |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, zero wait states |

## Verification
The bench builds the block with its default parameters: four slots and an 8-bit register. At this size every priority code and both socket straps can be covered exhaustively. For each code and strap, the bench raises all four requests at once and then releases owners one by one, which walks the whole fixed order. A long run with all slots requesting measures rotating fairness. Register writes made while an owner holds the bus show that a policy change waits for the next decision.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // policy selected by the mode bit of the control field
  typedef enum logic {
    POLICY_ROTATE = 1'b0,
    POLICY_FIXED  = 1'b1
  } arb_policy_e;

  localparam int CTRL_REG_W = 8;
endpackage

// File: rtl/dma_arb_ctrl_reg.sv
module dma_arb_ctrl_reg
  import dma_arb_pkg::*;
#(
  parameter int REG_W = CTRL_REG_W,
  parameter int PRI_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output arb_policy_e      policy,
  output logic [PRI_W-1:0] pri_code
);
  localparam int FIELD_W = PRI_W + 1;

  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= '0;
    end else if (cs && we) begin
      field_q <= wdata[FIELD_W-1:0];
    end
  end

  assign policy   = arb_policy_e'(field_q[PRI_W]);
  assign pri_code = field_q[PRI_W-1:0];
  assign rdata    = cs ? {{(REG_W-FIELD_W){1'b0}}, field_q} : '0;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int N_REQ = 4,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N_REQ; k++) begin
      int s;
      s = (int'(start) + k) % N_REQ;
      if (!found && req[s]) begin
        found = 1'b1;
        idx   = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/dma_arb_owner_map.sv
module dma_arb_owner_map #(
  parameter int N_REQ = 4,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             dual,
  output logic [IDX_W-1:0] socket,
  output logic             chan
);
  logic [IDX_W-1:0] sock_single [N_REQ];
  logic [IDX_W-1:0] sock_dual   [N_REQ];
  logic             chan_dual   [N_REQ];

  for (genvar g = 0; g < N_REQ; g++) begin : g_slot
    assign sock_single[g] = IDX_W'(g);
    assign sock_dual[g]   = IDX_W'((g / 2) * 2);
    assign chan_dual[g]   = 1'(g % 2);
  end

  assign socket = dual ? sock_dual[idx] : sock_single[idx];
  assign chan   = dual ? chan_dual[idx] : 1'b0;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int REG_W = CTRL_REG_W,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_dual_socket,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant,
  output logic             owner_valid,
  output logic [IDX_W-1:0] owner_socket,
  output logic             owner_chan,
  input  logic             reg_cs,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_REQ - 1);

  arb_policy_e      policy;
  logic [IDX_W-1:0] pri_code;
  logic [N_REQ-1:0] grant_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] start_idx;
  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic             hold;
  logic             next_valid;
  logic [IDX_W-1:0] next_idx;
  logic [IDX_W-1:0] map_socket;
  logic             map_chan;

  dma_arb_ctrl_reg #(.REG_W(REG_W), .PRI_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cs       (reg_cs),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .policy   (policy),
    .pri_code (pri_code)
  );

  // rotating: begin after the last winner; fixed: begin at the code
  always_comb begin
    if (policy == POLICY_FIXED) begin
      start_idx = pri_code;
    end else if (last_q == LAST_SLOT) begin
      start_idx = '0;
    end else begin
      start_idx = last_q + 1'b1;
    end
  end

  dma_arb_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_pick (
    .req   (req),
    .start (start_idx),
    .found (win_found),
    .idx   (win_idx)
  );

  assign hold       = |(grant_q & req);
  assign next_valid = hold | win_found;
  assign next_idx   = hold ? last_q : win_idx;

  dma_arb_owner_map #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_map (
    .idx    (next_idx),
    .dual   (cfg_dual_socket),
    .socket (map_socket),
    .chan   (map_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q      <= '0;
      last_q       <= LAST_SLOT;
      owner_valid  <= 1'b0;
      owner_socket <= '0;
      owner_chan   <= 1'b0;
    end else begin
      grant_q      <= next_valid ? (N_REQ'(1) << next_idx) : '0;
      owner_valid  <= next_valid;
      owner_socket <= next_valid ? map_socket : '0;
      owner_chan   <= next_valid ? map_chan : 1'b0;
      if (next_valid) begin
        last_q <= next_idx;
      end
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int N_REQ = 4,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req,
  input logic [N_REQ-1:0] grant,
  input logic [REG_W-1:0] reg_rdata,
  input logic             owner_valid
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (grant == '0 && !owner_valid));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:3] == '0);

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_requested_R4: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((grant & $past(req)) != '0));

  assert_idle_no_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (grant == '0));

  assert_no_preempt_R5: assert property (@(posedge clk) disable iff (rst)
    ((grant & req) != '0) |=> (grant == $past(grant)));

  assert_valid_tracks_grant_R4: assert property (@(posedge clk) disable iff (rst)
    owner_valid == (grant != '0));
endmodule

bind dma_bus_arbiter dma_arb_checker #(.N_REQ(N_REQ), .REG_W(REG_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .req         (req),
  .grant       (grant),
  .reg_rdata   (reg_rdata),
  .owner_valid (owner_valid)
);

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dual = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] grant;
  logic       owner_valid;
  logic [1:0] owner_socket;
  logic       owner_chan;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  int m_grant = -1;
  int m_last  = 3;
  int m_ctrl  = 0;

  always #2 clk = ~clk;

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk             (clk),
    .rst             (rst),
    .cfg_dual_socket (dual),
    .req             (req),
    .grant           (grant),
    .owner_valid     (owner_valid),
    .owner_socket    (owner_socket),
    .owner_chan      (owner_chan),
    .reg_cs          (cs),
    .reg_we          (we),
    .reg_wdata       (wdata),
    .reg_rdata       (rdata)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: update reference with pre-edge inputs, compare 1 ns later
  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_grant = -1; m_last = 3; m_ctrl = 0;
    end else begin
      if (!(m_grant >= 0 && req[m_grant])) begin
        int st;
        st = (m_ctrl & 4) ? (m_ctrl & 3) : (m_last + 1) % N;
        m_grant = -1;
        for (int k = 0; k < N; k++) begin
          if (m_grant < 0 && req[(st + k) % N]) m_grant = (st + k) % N;
        end
        if (m_grant >= 0) m_last = m_grant;
      end
      if (cs && we) m_ctrl = wdata & 7;
    end
    #1;
    chk("R4 grant", int'(grant), (m_grant >= 0) ? (1 << m_grant) : 0);
    chk(dual ? "R11 socket" : "R10 socket", int'(owner_socket),
        (m_grant < 0) ? 0 : (dual ? (m_grant / 2) * 2 : m_grant));
    chk(dual ? "R11 chan" : "R10 chan", int'(owner_chan),
        (m_grant < 0) ? 0 : (dual ? m_grant % 2 : 0));
    chk("R2 rdata", int'(rdata), cs ? m_ctrl : 0);
  endtask

  task automatic wr(logic [7:0] v);
    cs = 1; we = 1; wdata = v;
    step();
    we = 0; wdata = '0;
    step();
    cs = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt [4];
    int tenure [4];
    int prev;
    int seq_bad;

    #1;
    repeat (3) step();
    rst = 0;
    step();
    // R1: reset state
    cs = 1;
    step();
    chk("R1 grant after reset", int'(grant), 0);
    chk("R1 ctrl after reset", int'(rdata), 0);
    cs = 0;

    // R2 / R3 register access
    wr(8'hFF);
    cs = 1; step();
    chk("R2 reserved bits read zero", int'(rdata), 7);
    we = 0; wdata = 8'h00; step();
    chk("R3 read-only cycle keeps value", int'(rdata), 7);
    cs = 0; we = 1; step();
    we = 0; cs = 1; step();
    chk("R3 write without cs ignored", int'(rdata), 7);
    cs = 0; step();
    chk("R2 rdata zero without cs", int'(rdata), 0);
    wr(8'h00);

    // R7 rotating order from reset start
    req = 4'b1010; step();
    chk("R7 first rotating winner", int'(grant), 4'b0010);
    req = 4'b1000; step();
    chk("R6 handoff same edge", int'(grant), 4'b1000);
    req = 4'b1011; step(); step();
    chk("R5 owner held", int'(grant), 4'b1000);
    req = 4'b0011; step();
    chk("R7 wrap after slot 3", int'(grant), 4'b0001);
    req = 4'b0000; step();
    chk("R4 idle no grant", int'(grant), 0);

    // R8 fixed orders, both socket maps (R10, R11)
    for (int d = 0; d < 2; d++) begin
      dual = 1'(d);
      for (int p = 0; p < 4; p++) begin
        wr(8'hF8 | 8'h04 | 8'(p));
        req = 4'hF; step();
        chk("R8 fixed top slot", int'(grant), 1 << p);
        chk(d ? "R11 owner socket" : "R10 owner socket", int'(owner_socket),
            d ? (p / 2) * 2 : p);
        for (int k = 1; k < 4; k++) begin
          req[(p + k - 1) % 4] = 1'b0;
          step();
          chk("R8 fixed order", int'(grant), 1 << ((p + k) % 4));
        end
        req = '0; step();
      end
    end
    dual = 0;

    // R9 write while owning does not disturb owner
    wr(8'h04);
    req = 4'b0100; step();
    chk("R9 owner before write", int'(grant), 4'b0100);
    req = 4'b1111;
    cs = 1; we = 1; wdata = 8'h06; step();
    we = 0; cs = 0; step();
    chk("R9 owner kept after write", int'(grant), 4'b0100);
    req = 4'b1011; step();
    chk("R9 new code used next decision", int'(grant), 4'b1000);
    req = '0; step();

    // R12 fairness in rotating mode
    wr(8'h00);
    for (int i = 0; i < 4; i++) begin cnt[i] = 0; tenure[i] = 0; end
    prev = -1; seq_bad = 0;
    req = 4'hF;
    for (int c = 0; c < 160; c++) begin
      step();
      if (m_grant >= 0 && m_grant != prev) begin
        if (prev >= 0 && m_grant != (prev + 1) % 4) seq_bad++;
        cnt[m_grant]++;
        prev = m_grant;
      end
      for (int i = 0; i < 4; i++) begin
        if (m_grant == i) begin
          tenure[i]++;
          req[i] = (tenure[i] < 2);
          if (tenure[i] >= 2) tenure[i] = 0;
        end else begin
          req[i] = 1'b1;
        end
      end
    end
    chk("R12 rotation sequence breaks", seq_bad, 0);
    for (int i = 1; i < 4; i++) begin
      chk("R12 equal grant counts", cnt[i], cnt[0]);
    end
    req = '0; step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule